// File: doc/BRIEF.md
# Serial-Addressed Relay Output Register

This block takes write frames from a three-wire serial link and turns them into the settings of an eight-channel on/off output bank and of a separate eight-bit power-save configuration register. The host pulls the select line low, clocks bits in most significant bit first on rising serial clock edges, and then releases select. The release decodes whatever the shift register holds at that moment. By default a frame is an address byte followed by a data byte. Address 00h writes the channel bank, address 01h writes the power-save register, and any other address writes nothing.

A parameter selects a short variant. In that variant a frame is a single data byte that always goes to the channel bank. A serial output presents the oldest bit in the shift register, so several devices can be chained. The select, serial clock and serial data inputs are brought into the system clock domain through synchroniser stages and then edge-detected. A one-cycle strobe marks every write of the channel bank.

Top module: `relay_serial_reg`

## Requirements
- R1: With SHORT_FRAME=0 a frame is 16 bits: the first eight bits received form the address (the first bit received is address bit 7), and the last eight form the data (the last bit received is data bit 0). Data bit n controls chan_on[n]: 1 means on, 0 means off.
- R2: On a rising edge of sel_n, when the address is 00h, chan_on takes the data byte.
- R3: On a rising edge of sel_n, when the address is 01h, psave_cfg takes the data byte and chan_on is left unchanged.
- R4: On a rising edge of sel_n, when the address is neither 00h nor 01h, chan_on and psave_cfg both keep their values. The received bits stay in the shift register.
- R5: While sel_n is low, chan_on holds its previous value whatever is clocked in.
- R6: While sel_n is high, edges on sclk_in and sdin leave the shift register unchanged. A later rising edge of sel_n therefore decodes the same contents again.
- R7: If more or fewer than a full frame of bits is clocked while sel_n is low, the decode uses the last 16 bits received (the last 8 bits with SHORT_FRAME=1). Fewer bits mix with older shift-register contents.
- R8: With SHORT_FRAME=1 a frame is 8 data bits and has no address. Every rising edge of sel_n loads the byte into chan_on, and psave_cfg stays zero.
- R9: While sel_n is high, sdout equals the oldest bit in the shift register: bit 15 in full mode, bit 7 in short mode.
- R10: An active-low synchronous reset clears chan_on, psave_cfg, the shift register and chan_upd to zero.
- R11: chan_upd is high for exactly one clock cycle after each write of chan_on, including a write of an unchanged value. It is never high otherwise, and chan_on never changes without it.
- R12: sdin is sampled on the rising edge of sclk_in. All three serial inputs pass through SYNC_STAGES flip-flops before use, so an input level must be stable for more than SYNC_STAGES+1 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Frame select, active low; its rising edge commits the frame |
| sclk_in | input | 1 | Serial bit clock; the rising edge samples sdin |
| sdin | input | 1 | Serial data in, most significant bit first |
| sdout | output | 1 | Oldest bit of the shift register, for chaining |
| chan_on | output | 8 | Channel on/off states |
| psave_cfg | output | 8 | Power-save configuration register |
| chan_upd | output | 1 | One-cycle pulse on each write of chan_on |

## Verification
The embedded assertions check the following on every cycle:
- the channel bank cannot move while select is low;
- the shift register is frozen while select is high;
- the update strobe lasts one cycle and only follows a select rising edge;
- every change of the channel bank is accompanied by the strobe;
- the power-save register changes only after a frame addressed 01h.

Only the bench scenarios show the following:
- that the right byte lands in the right register;
- that over-long and short bit counts keep the last frame-width bits;
- that frames with other addresses leave both registers unchanged;
- that sdout tracks the oldest shifted bit.

A second instance in short mode is driven with the same stimulus so that both frame formats are compared against their own models.

// File: rtl/relay_serial_reg.sv
module relay_serial_reg #(
  parameter bit SHORT_FRAME = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       sclk_in,
  input  logic       sdin,
  output logic       sdout,
  output logic [7:0] chan_on,
  output logic [7:0] psave_cfg,
  output logic       chan_upd
);
  localparam int FW = SHORT_FRAME ? 8 : 16;
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cs_sync, ck_sync, dt_sync;
  logic cs_prev, ck_prev;
  logic [FW-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_sync <= '1;
      ck_sync <= '0;
      dt_sync <= '0;
      cs_prev <= 1'b1;
      ck_prev <= 1'b0;
    end else begin
      cs_sync <= {cs_sync[SYNC_STAGES-2:0], sel_n};
      ck_sync <= {ck_sync[SYNC_STAGES-2:0], sclk_in};
      dt_sync <= {dt_sync[SYNC_STAGES-2:0], sdin};
      cs_prev <= cs_sync[LAST];
      ck_prev <= ck_sync[LAST];
    end
  end

  wire cs_s    = cs_sync[LAST];
  wire ck_rise = ck_sync[LAST] & ~ck_prev;
  wire commit  = cs_s & ~cs_prev;

  always_ff @(posedge clk) begin
    if (!rst_n)                shift_q <= '0;
    else if (!cs_s && ck_rise) shift_q <= {shift_q[FW-2:0], dt_sync[LAST]};
  end

  assign sdout = shift_q[FW-1];

  generate
    if (SHORT_FRAME) begin : g_short
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chan_on  <= '0;
          chan_upd <= 1'b0;
        end else begin
          chan_upd <= commit;
          if (commit) chan_on <= shift_q[7:0];
        end
      end
      assign psave_cfg = '0;
    end else begin : g_full
      wire [7:0] addr = shift_q[15:8];
      wire [7:0] data = shift_q[7:0];
      logic [7:0] ps_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          chan_on  <= '0;
          ps_q     <= '0;
          chan_upd <= 1'b0;
        end else begin
          chan_upd <= commit && addr == 8'h00;
          if (commit && addr == 8'h00) chan_on <= data;
          if (commit && addr == 8'h01) ps_q <= data;
        end
      end
      assign psave_cfg = ps_q;

      assert_psave_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psave_cfg != $past(psave_cfg)) |-> ($past(commit) && $past(shift_q[15:8]) == 8'h01));
    end
  endgenerate

  assert_hold_while_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> $stable(chan_on));
  assert_shift_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(shift_q));
  assert_strobe_after_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chan_upd |-> ($past(cs_s) && !$past(cs_prev)));
  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chan_upd |=> !chan_upd);
  assert_change_has_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on != $past(chan_on)) |-> chan_upd);
endmodule

// File: tb/relay_serial_reg_tb.sv
module relay_serial_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, sel_n = 1, sclk_in = 0, sdin = 0;
  logic sdout, upd, sdout_s, upd_s, unused_s;
  logic [7:0] chan_on, psave_cfg, chan_s, ps_s;

  int checks = 0, errors = 0;
  int upd_cnt = 0, upd_cnt_s = 0, exp_upd = 0, exp_upd_s = 0;
  logic [15:0] mshift = 0;
  logic [7:0]  sshift = 0, exp_out = 0, exp_ps = 0, exp_out_s = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  relay_serial_reg #(.SHORT_FRAME(1'b0)) u_dut (.clk, .rst_n, .sel_n, .sclk_in, .sdin,
    .sdout(sdout), .chan_on(chan_on), .psave_cfg(psave_cfg), .chan_upd(upd));
  relay_serial_reg #(.SHORT_FRAME(1'b1)) u_dut_short (.clk, .rst_n, .sel_n, .sclk_in, .sdin,
    .sdout(sdout_s), .chan_on(chan_s), .psave_cfg(ps_s), .chan_upd(upd_s));
  assign unused_s = 1'b0;

  always @(posedge clk) begin
    if (upd)   upd_cnt++;
    if (upd_s) upd_cnt_s++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, input bit model);
    sdin = b;
    wait_clk(HALF);
    sclk_in = 1;
    wait_clk(HALF);
    sclk_in = 0;
    if (model) begin
      mshift = {mshift[14:0], b};
      sshift = {sshift[6:0], b};
    end
  endtask

  task automatic check_all(input string tag);
    check(chan_on == exp_out, {tag, " full chan_on"}, chan_on, exp_out);
    check(psave_cfg == exp_ps, {tag, " full psave_cfg"}, psave_cfg, exp_ps);
    check(sdout == mshift[15], "R9 full sdout", sdout, mshift[15]);
    check(upd_cnt == exp_upd, "R11 full strobe count", upd_cnt, exp_upd);
    check(chan_s == exp_out_s, "R8 short chan_on", chan_s, exp_out_s);
    check(ps_s == 8'h00, "R8 short psave stays zero", ps_s, 0);
    check(sdout_s == sshift[7], "R9 short sdout", sdout_s, sshift[7]);
    check(upd_cnt_s == exp_upd_s, "R11 short strobe count", upd_cnt_s, exp_upd_s);
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input string tag);
    sel_n = 0;
    wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      clock_bit(bits[i], 1'b1);
      if (i == n / 2) begin
        check(chan_on == exp_out, "R5 hold mid-frame", chan_on, exp_out);
        check(upd_cnt == exp_upd, "R5 no strobe mid-frame", upd_cnt, exp_upd);
      end
    end
    wait_clk(HALF);
    sel_n = 1;
    if (mshift[15:8] == 8'h00) begin exp_out = mshift[7:0]; exp_upd++; end
    if (mshift[15:8] == 8'h01) exp_ps = mshift[7:0];
    exp_out_s = sshift;
    exp_upd_s++;
    wait_clk(8);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1977);
    sclk_in = 1; sdin = 1;
    wait_clk(5);
    rst_n = 1; sclk_in = 0; sdin = 0;
    wait_clk(6);
    check_all("R10 reset");

    frame({16'h0, 16'h00A5}, 16, "R1 R2 addr00");
    frame({16'h0, 16'h013C}, 16, "R3 addr01");
    frame({16'h0, 16'h7E55}, 16, "R4 other addr");
    check(sdout == 1'b0, "R4 addr kept in shift (sdout=A7)", sdout, 0);
    frame({16'h0, 16'h80FF}, 16, "R4 addr80");
    check(sdout == 1'b1, "R4 addr kept in shift (sdout=A7)", sdout, 1);
    frame({12'h0, 20'hF_00C3}, 20, "R7 overlong");
    frame({16'h0, 16'h0081}, 12, "R7 short count");
    frame({16'h0, 16'h0000}, 0, "R7 zero bits");
    frame({16'h0, 16'h0081}, 16, "R11 rewrite");
    frame({16'h0, 16'h0081}, 16, "R11 rewrite same value");

    for (int k = 0; k < 6; k++) clock_bit(k[0], 1'b0);
    wait_clk(6);
    check(sdout == mshift[15], "R6 sdout unchanged with sel high", sdout, mshift[15]);
    frame({16'h0, 16'h0000}, 0, "R6 recommit after ignored clocks");

    for (int f = 0; f < 40; f++) begin
      logic [31:0] bits;
      int n, sel;
      bits = $urandom;
      sel = int'($urandom_range(0, 3));
      if (sel == 0) bits[15:8] = 8'h00;
      else if (sel == 1) bits[15:8] = 8'h01;
      n = (f % 4 == 0) ? int'($urandom_range(6, 22)) : 16;
      frame(bits, n, "R12 random frame");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule